// File: doc/BRIEF.md
# Address-Selected State Cell Array

This block holds a row of state bits that a test controller reaches one at a time by address, rather than by pushing bits through a serial shift chain. A small address register is filled serially, one bit per edge of its own address clock. A decoder turns that address into one select line per cell. When test control is high, only the selected cell drives the single scan output, and only that cell takes the scan input on the system clock edge. Every other cell keeps its value.

When test control is low, the array works as ordinary functional flops: every cell captures its functional input on each system clock edge, and the scan output is held at 0. A controller can therefore capture a functional vector, change exactly one state bit by address, and then apply the next functional clock. This is how single-input-change vector pairs are built.

The cell update is a per-cell choice among three named operations. CAPTURE loads the functional input and applies in normal mode. WRITE loads the scan input and applies to the selected cell in test mode. HOLD keeps the value and applies to the unselected cells in test mode. The address register has two named behaviours: SHIFT when the load enable is high, and KEEP when it is low.

Top module: `ras_array`

## Requirements
- R1: After reset is asserted (rst_n low), every cell reads 0, the address register holds 0 (so a test-mode write with no address load goes to cell 0), and scan_out reads 0.
- R2: On each rising edge of addr_clk with addr_ld_en high, the address register shifts left and takes addr_si into its LSB, so an address is loaded most significant bit first. With addr_ld_en low, addr_clk edges leave the address unchanged.
- R3: While test_en is high and the address is below NFF, scan_out equals the state bit of the addressed cell, with no clock delay.
- R4: While test_en is high, a rising clk edge writes scan_in into the addressed cell only. All other cells keep their values.
- R5: While test_en is low, every cell loads its bit of func_d on each rising clk edge, whatever the address.
- R6: While test_en is low, scan_out reads 0.
- R7: An address at or above NFF selects no cell. In test mode a clk edge then changes no state bit, and scan_out reads 0.
- R8: Between two functional captures, one test-mode write makes the state differ from the first captured vector in exactly the one addressed bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the state cells |
| rst_n | input | 1 | Asynchronous active-low reset for cells and address register |
| test_en | input | 1 | Test control: 1 = addressed access, 0 = functional capture |
| scan_in | input | 1 | Bit written into the selected cell in test mode |
| scan_out | output | 1 | Value of the selected cell in test mode, else 0 |
| addr_clk | input | 1 | Clock of the address register |
| addr_ld_en | input | 1 | Enables serial address shifting |
| addr_si | input | 1 | Serial address input, MSB first |
| func_d | input | NFF | Functional next-state inputs |
| state_q | output | NFF | Current contents of the state cells |

## Verification
The hardest situation to reach is an addressed read that does not disturb the cell being read. In test mode every system edge writes into the selected cell. To get around this, the bench loads the address between two system edges, raises test control only for the part of a period that contains no edge, and then drops it. During that window it feeds func_d with the state it expects, so the next functional capture leaves the array unchanged. Out-of-range addresses, and address-clock pulses with the load enable low, are reached the same way. Their absence of effect is then shown through scan_out and state_q.

// File: rtl/ras_pkg.sv
package ras_pkg;

    // Per-cell update operation
    typedef enum logic [1:0] {
        CELL_CAPTURE = 2'd0,
        CELL_WRITE   = 2'd1,
        CELL_HOLD    = 2'd2
    } cell_op_e;

    // Address register behaviour
    typedef enum logic {
        ADDR_KEEP  = 1'b0,
        ADDR_SHIFT = 1'b1
    } addr_op_e;

    function automatic int addr_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ras_addr_reg.sv
module ras_addr_reg
    import ras_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              addr_clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic              si,
    output logic [ADDR_W-1:0] addr
);

    addr_op_e                 op;
    logic     [ADDR_W-1:0]    addr_nxt;

    always_comb begin
        op = ld_en ? ADDR_SHIFT : ADDR_KEEP;
    end

    always_comb begin
        unique case (op)
            ADDR_SHIFT: begin
                if (ADDR_W > 1) begin
                    addr_nxt = {addr[ADDR_W-2:0], si};
                end else begin
                    addr_nxt = ADDR_W'(si);
                end
            end
            ADDR_KEEP:  addr_nxt = addr;
            default:    addr_nxt = addr;
        endcase
    end

    always_ff @(posedge addr_clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else begin
            addr <= addr_nxt;
        end
    end

endmodule

// File: rtl/ras_decoder.sv
module ras_decoder #(
    parameter int NFF    = 6,
    parameter int ADDR_W = 3
) (
    input  logic              test_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NFF-1:0]    sel
);

    // One select line per cell, forced low outside test mode
    for (genvar i = 0; i < NFF; i++) begin : g_sel
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
        assign sel[i] = test_en && (addr == IDX);
    end

endmodule

// File: rtl/ras_cell_array.sv
module ras_cell_array
    import ras_pkg::*;
#(
    parameter int NFF = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           test_en,
    input  logic           scan_in,
    input  logic [NFF-1:0] sel,
    input  logic [NFF-1:0] func_d,
    output logic [NFF-1:0] q,
    output logic           scan_out
);

    for (genvar i = 0; i < NFF; i++) begin : g_cell
        cell_op_e op;
        logic     d_nxt;

        always_comb begin
            if (!test_en) begin
                op = CELL_CAPTURE;
            end else if (sel[i]) begin
                op = CELL_WRITE;
            end else begin
                op = CELL_HOLD;
            end
        end

        always_comb begin
            unique case (op)
                CELL_CAPTURE: d_nxt = func_d[i];
                CELL_WRITE:   d_nxt = scan_in;
                CELL_HOLD:    d_nxt = q[i];
                default:      d_nxt = q[i];
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else begin
                q[i] <= d_nxt;
            end
        end
    end

    // Only the selected cell reaches the output; an empty select yields 0
    always_comb begin
        scan_out = |(sel & q);
    end

endmodule

// File: rtl/ras_array.sv
module ras_array
    import ras_pkg::*;
#(
    parameter int NFF = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           test_en,
    input  logic           scan_in,
    output logic           scan_out,
    input  logic           addr_clk,
    input  logic           addr_ld_en,
    input  logic           addr_si,
    input  logic [NFF-1:0] func_d,
    output logic [NFF-1:0] state_q
);

    localparam int ADDR_W = addr_width(NFF);

    logic [ADDR_W-1:0] addr_q;
    logic [NFF-1:0]    sel;

    ras_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
        .addr_clk (addr_clk),
        .rst_n    (rst_n),
        .ld_en    (addr_ld_en),
        .si       (addr_si),
        .addr     (addr_q)
    );

    ras_decoder #(.NFF(NFF), .ADDR_W(ADDR_W)) u_dec (
        .test_en (test_en),
        .addr    (addr_q),
        .sel     (sel)
    );

    ras_cell_array #(.NFF(NFF)) u_cells (
        .clk      (clk),
        .rst_n    (rst_n),
        .test_en  (test_en),
        .scan_in  (scan_in),
        .sel      (sel),
        .func_d   (func_d),
        .q        (state_q),
        .scan_out (scan_out)
    );

endmodule

// File: rtl/ras_array_chk.sv
module ras_array_chk #(
    parameter int NFF    = 6,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              test_en,
    input logic              scan_in,
    input logic              scan_out,
    input logic [ADDR_W-1:0] addr_q,
    input logic [NFF-1:0]    sel,
    input logic [NFF-1:0]    func_d,
    input logic [NFF-1:0]    state_q
);

    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |=> state_q == $past(func_d));

    a_r4_one_cell_only: assert property (@(posedge clk) disable iff (!rst_n)
        test_en |=> $countones(state_q ^ $past(state_q)) <= 1);

    a_r4_write_value: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && (int'(addr_q) < NFF)) |=> 1'(state_q >> $past(addr_q)) == $past(scan_in));

    a_r3_read_selected: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && (int'(addr_q) < NFF)) |-> scan_out == 1'(state_q >> addr_q));

    a_r3_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel));

    a_r6_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !test_en |-> !scan_out);

    a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && (int'(addr_q) >= NFF)) |=> state_q == $past(state_q));

    a_r7_out_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (test_en && (int'(addr_q) >= NFF)) |-> !scan_out);

endmodule

bind ras_array ras_array_chk #(.NFF(NFF), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .test_en  (test_en),
    .scan_in  (scan_in),
    .scan_out (scan_out),
    .addr_q   (addr_q),
    .sel      (sel),
    .func_d   (func_d),
    .state_q  (state_q)
);

// File: tb/sim_ras_array.sv
`timescale 1ns/1ps
module sim_ras_array;

    localparam int NFF    = 6;
    localparam int ADDR_W = (NFF > 1) ? $clog2(NFF) : 1;
    localparam int NADDR  = 1 << ADDR_W;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           test_en = 1'b0;
    logic           scan_in = 1'b0;
    logic           scan_out;
    logic           addr_clk = 1'b0;
    logic           addr_ld_en = 1'b0;
    logic           addr_si = 1'b0;
    logic [NFF-1:0] func_d = '0;
    logic [NFF-1:0] state_q;

    logic [NFF-1:0] model = '0;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ras_array #(.NFF(NFF)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_en    (test_en),
        .scan_in    (scan_in),
        .scan_out   (scan_out),
        .addr_clk   (addr_clk),
        .addr_ld_en (addr_ld_en),
        .addr_si    (addr_si),
        .func_d     (func_d),
        .state_q    (state_q)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Runs 1 ns after a clk edge and ends 1 + 2*ADDR_W ns later, with no clk edge inside
    task automatic load_addr(input int a, input bit en);
        @(posedge clk);
        #1;
        func_d = model;
        addr_ld_en = en;
        for (int b = ADDR_W - 1; b >= 0; b--) begin
            addr_si = a[b];
            #1 addr_clk = 1'b1;
            #1 addr_clk = 1'b0;
        end
        addr_ld_en = 1'b0;
        addr_si = 1'b0;
    endtask

    // Write one bit through the current address; checks state after the edge
    task automatic write_cur(input int a, input bit v, input string req);
        test_en = 1'b1;
        scan_in = v;
        @(posedge clk);
        #1;
        test_en = 1'b0;
        if (a < NFF) model[a] = v;
        func_d = model;
        check(req, 64'(state_q), 64'(model));
    endtask

    // Read through the current address without any clk edge while test_en is high
    task automatic read_cur(input bit exp, input string req);
        #1;
        test_en = 1'b1;
        #1;
        check(req, 64'(scan_out), 64'(exp));
        test_en = 1'b0;
    endtask

    task automatic t_reset;
        #2;
        check("R1 state", 64'(state_q), 64'(0));
        check("R1 scan_out", 64'(scan_out), 64'(0));
        @(posedge clk);
        #1;
        write_cur(0, 1'b1, "R1 default address 0");
        load_addr(0, 1'b1);
        read_cur(1'b1, "R3 read cell 0");
        write_cur(0, 1'b0, "R4 clear cell 0");
    endtask

    task automatic t_capture;
        logic [NFF-1:0] pats [3];
        pats[0] = NFF'(6'h2A);
        pats[1] = NFF'(6'h15);
        pats[2] = NFF'(6'h3F);
        for (int p = 0; p < 3; p++) begin
            @(posedge clk);
            #1;
            func_d = pats[p];
            @(posedge clk);
            #1;
            model = pats[p];
            check("R5 capture", 64'(state_q), 64'(model));
            check("R6 scan_out quiet", 64'(scan_out), 64'(0));
        end
    endtask

    task automatic t_walk;
        for (int rnd = 0; rnd < 2; rnd++) begin
            for (int a = 0; a < NFF; a++) begin
                bit v;
                v = ~model[a];
                load_addr(a, 1'b1);
                write_cur(a, v, "R4 addressed write");
                load_addr(a, 1'b1);
                read_cur(v, "R3 read back");
                check("R4 others intact", 64'(state_q), 64'(model));
            end
        end
    endtask

    task automatic t_out_of_range;
        for (int a = NFF; a < NADDR; a++) begin
            load_addr(a, 1'b1);
            write_cur(a, 1'b1, "R7 no cell written");
            load_addr(a, 1'b1);
            read_cur(1'b0, "R7 scan_out zero");
        end
    endtask

    task automatic t_addr_hold;
        load_addr(2, 1'b1);
        load_addr(NADDR - 1, 1'b0);
        write_cur(2, ~model[2], "R2 address kept when load disabled");
        load_addr(4 % NFF, 1'b1);
        read_cur(model[4 % NFF], "R2 msb-first address");
    endtask

    task automatic t_sic;
        logic [NFF-1:0] v1;
        @(posedge clk);
        #1;
        func_d = NFF'(6'h0C);
        @(posedge clk);
        #1;
        model = NFF'(6'h0C);
        v1 = state_q;
        load_addr(3, 1'b1);
        write_cur(3, ~v1[3], "R8 single write");
        check("R8 one bit differs", 64'(state_q ^ v1), 64'(1) << 3);
        func_d = NFF'(6'h21);
        @(posedge clk);
        #1;
        model = NFF'(6'h21);
        check("R8 next capture", 64'(state_q), 64'(model));
    endtask

    initial begin
        #500ns;
        #(200000 * 10ns);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #12 rst_n = 1'b1;
        t_reset();
        t_capture();
        t_walk();
        t_out_of_range();
        t_addr_hold();
        t_sic();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule